// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block owns the fetch address of a small processor core. Every instruction cycle it either advances the address by one, jumps to a subroutine, comes back from one, or lets the execute unit throw away the word just fetched. A subroutine jump builds its 13-bit destination from an 11-bit immediate plus two page bits. The page bits come from a separate page register that software loads beforehand. The address to come back to is saved in a small circular hardware stack.

Jumps, returns and skips each take two instruction cycles. In the cycle after one of them is accepted, the block raises a flag that tells the execute unit to treat the word in flight as a no-op. Strobes that arrive during that no-op cycle belong to no real instruction, so the block ignores them. Status flags are not part of this block, and none of these operations touch them.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, clears the no-op flag, sets the stack pointer to its first slot and zeroes every stack entry.
- R2: In a cycle with no accepted call or return, the fetch address at the next edge is the current one plus 1, modulo 8192 (8191 is followed by 0).
- R3: An accepted call loads fetch address bits 10..0 from the 11-bit target and bits 12..11 from bits 4..3 of the page latch input.
- R4: An accepted call pushes (current fetch address + 1) mod 8192. An accepted return loads the fetch address from the most recently pushed entry and pops it.
- R5: The no-op flag is high for exactly the one cycle that follows an accepted call, return or skip. Any call, return or skip strobe seen while the flag is high is ignored, and the address simply advances by one.
- R6: An accepted skip advances the fetch address by one like a plain cycle, and raises the no-op flag for the next cycle.
- R7: When several strobes are high in an accepted cycle, call wins over return, and return wins over skip. Only the winner takes effect.
- R8: The stack holds 8 entries and is circular. A ninth push without a pop overwrites the oldest entry. A pop with nothing pushed reads the slot below the pointer with wraparound, and no error is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Subroutine call strobe |
| call_target_i | input | 11 | Immediate call destination within a page |
| ret_i | input | 1 | Return strobe |
| skip_i | input | 1 | Discard-next-instruction request from execute |
| page_latch_i | input | 8 | Page register; bits 4..3 supply address bits 12..11 on a call |
| fetch_addr_o | output | 13 | Current fetch address |
| nop_cycle_o | output | 1 | High when the current cycle is a forced no-op |

## Verification
The fetch address and the no-op flag both come straight from registers. A strobe applied before clock edge n therefore shows its full effect, whether the new address or the raised flag, in the cycle right after edge n. A return pushed by an earlier call shows up one cycle after the return strobe. The bench drives inputs and compares outputs at the falling edge. It updates its behavioural model once per driven cycle, so each comparison lines up with the one register stage between the inputs and the outputs. The wraparound of the address and of the stack pointer is checked with directed sequences. Priority and ignored-strobe cases are checked both with directed steps and with a long random mix.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W      = 13;
    localparam int IMM_W     = 11;
    localparam int PAGE_W    = 8;
    localparam int PAGE_LSB  = 3;
    localparam int PAGE_BITS = PC_W - IMM_W;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [IMM_W-1:0]  imm_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [1:0] {
        ACT_SEQ  = 2'd0,
        ACT_CALL = 2'd1,
        ACT_RET  = 2'd2,
        ACT_SKIP = 2'd3
    } act_e;

    typedef struct packed {
        act_e act;
        pc_t  next_pc;
        logic push;
        logic pop;
        logic nop_next;
    } seq_ctl_t;

    function automatic pc_t pc_step(input pc_t cur);
        return cur + pc_t'(1);
    endfunction

    function automatic pc_t call_dest(input imm_t imm, input page_t page);
        return {page[PAGE_LSB +: PAGE_BITS], imm};
    endfunction

endpackage

// File: rtl/pcs_retstack.sv
module pcs_retstack
    import pcs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_data,
    output pc_t  tos
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] top_idx;
    pc_t              slot_q [DEPTH];

    assign top_idx = ptr_q - PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end else if (pop) begin
            ptr_q <= top_idx;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (push && (ptr_q == PTR_W'(g))) begin
                slot_q[g] <= push_data;
            end
        end
    end

    assign tos = slot_q[top_idx];

    // R4
    push_visible_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> tos == $past(push_data));

    // R8
    pop_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ptr_q == $past(ptr_q) - PTR_W'(1));

    // R7
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, pop}));

endmodule

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
    import pcs_pkg::*;
(
    input  logic     nop_now,
    input  logic     call_i,
    input  logic     ret_i,
    input  logic     skip_i,
    input  pc_t      cur_pc,
    input  imm_t     target,
    input  page_t    page,
    input  pc_t      tos,
    output seq_ctl_t ctl
);
    act_e act;

    always_comb begin
        if (nop_now)     act = ACT_SEQ;
        else if (call_i) act = ACT_CALL;
        else if (ret_i)  act = ACT_RET;
        else if (skip_i) act = ACT_SKIP;
        else             act = ACT_SEQ;
    end

    always_comb begin
        ctl.act      = act;
        ctl.push     = (act == ACT_CALL);
        ctl.pop      = (act == ACT_RET);
        ctl.nop_next = (act != ACT_SEQ);
        unique case (act)
            ACT_CALL: ctl.next_pc = call_dest(target, page);
            ACT_RET:  ctl.next_pc = tos;
            default:  ctl.next_pc = pc_step(cur_pc);
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic [IMM_W-1:0]  call_target_i,
    input  logic              ret_i,
    input  logic              skip_i,
    input  logic [PAGE_W-1:0] page_latch_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              nop_cycle_o
);
    pc_t      pc_q;
    logic     nop_q;
    pc_t      tos;
    seq_ctl_t ctl;

    pcs_next_sel u_sel (
        .nop_now (nop_q),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .skip_i  (skip_i),
        .cur_pc  (pc_q),
        .target  (call_target_i),
        .page    (page_latch_i),
        .tos     (tos),
        .ctl     (ctl)
    );

    pcs_retstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .pop       (ctl.pop),
        .push_data (pc_step(pc_q)),
        .tos       (tos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            nop_q <= 1'b0;
        end else begin
            pc_q  <= ctl.next_pc;
            nop_q <= ctl.nop_next;
        end
    end

    assign fetch_addr_o = pc_q;
    assign nop_cycle_o  = nop_q;

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!nop_cycle_o && !call_i && !ret_i) |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

    // R3
    call_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (!nop_cycle_o && call_i) |=>
        fetch_addr_o == {$past(page_latch_i[PAGE_LSB +: PAGE_BITS]), $past(call_target_i)});

    // R5
    nop_single_chk: assert property (@(posedge clk) disable iff (rst)
        nop_cycle_o |=> !nop_cycle_o);

    // R5
    nop_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        nop_cycle_o |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

    // R6
    nop_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!nop_cycle_o && (call_i || ret_i || skip_i)) |=> nop_cycle_o);

endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_i;
    logic [10:0] call_target_i;
    logic        ret_i;
    logic        skip_i;
    logic [7:0]  page_latch_i;
    logic [12:0] fetch_addr_o;
    logic        nop_cycle_o;

    int checks = 0;
    int errors = 0;

    int m_pc;
    int m_nop;
    int m_sp;
    int m_stk [8];

    always #5 clk = ~clk;

    pc_sequencer dut (
        .clk           (clk),
        .rst           (rst),
        .call_i        (call_i),
        .call_target_i (call_target_i),
        .ret_i         (ret_i),
        .skip_i        (skip_i),
        .page_latch_i  (page_latch_i),
        .fetch_addr_o  (fetch_addr_o),
        .nop_cycle_o   (nop_cycle_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_nop = 0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
    endtask

    // drive one cycle at the falling edge, advance the model, compare at the next falling edge
    task automatic step(input bit c, input bit r, input bit s,
                        input int imm, input int page, input string req);
        call_i = c; ret_i = r; skip_i = s;
        call_target_i = 11'(imm); page_latch_i = 8'(page);
        if (m_nop == 0 && c) begin
            m_stk[m_sp] = (m_pc + 1) % 8192;
            m_sp = (m_sp + 1) % 8;
            m_pc = ((page >> 3) & 3) * 2048 + (imm & 2047);
            m_nop = 1;
        end else if (m_nop == 0 && r) begin
            m_sp = (m_sp + 7) % 8;
            m_pc = m_stk[m_sp];
            m_nop = 1;
        end else if (m_nop == 0 && s) begin
            m_pc = (m_pc + 1) % 8192;
            m_nop = 1;
        end else begin
            m_pc = (m_pc + 1) % 8192;
            m_nop = 0;
        end
        @(negedge clk);
        check(req, int'(fetch_addr_o), m_pc, "fetch_addr");
        check(req, int'(nop_cycle_o), m_nop, "nop_cycle");
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; call_i = 0; ret_i = 0; skip_i = 0;
        call_target_i = '0; page_latch_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(fetch_addr_o), 0, "reset fetch_addr");
        check("R1", int'(nop_cycle_o), 0, "reset nop_cycle");
        model_reset();
        rst = 1'b0;

        // R2: plain advance
        idle(5, "R2");

        // R3 / R4: call with page bits 01, then strobes during the no-op cycle (R5)
        step(1, 0, 0, 'h123, 'h08, "R3");
        step(1, 1, 1, 'h555, 'h18, "R5");
        idle(3, "R2");
        step(0, 1, 0, 0, 0, "R4");
        idle(2, "R2");

        // R6: skip, then skip during the no-op cycle
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 0, 0, "R5");
        idle(1, "R2");

        // R7: priority
        step(1, 1, 1, 'h0AA, 'h10, "R7");
        idle(1, "R7");
        step(0, 1, 1, 0, 0, "R7");
        idle(1, "R7");

        // R2: wrap from 8191 to 0
        step(1, 0, 0, 'h7FF, 'h18, "R3");
        step(0, 0, 0, 0, 0, "R2");
        idle(1, "R2");

        // R8: nine nested calls, then ten returns
        for (int k = 0; k < 9; k++) begin
            step(1, 0, 0, 100 * k + 7, k << 3, "R8");
            idle(1, "R8");
        end
        for (int k = 0; k < 10; k++) begin
            step(0, 1, 0, 0, 0, "R8");
            idle(1, "R8");
        end

        // random mix; R1 again through a mid-run reset
        for (int n = 0; n < 2000; n++) begin
            int sel = $urandom_range(0, 9);
            step(sel == 0, sel == 1 || sel == 3, sel == 2 || sel == 3,
                 $urandom_range(0, 2047), $urandom_range(0, 255), "R7");
        end
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(fetch_addr_o), 0, "re-reset fetch_addr");
        rst = 1'b0;
        model_reset();
        step(0, 1, 0, 0, 0, "R1");
        idle(2, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule